// File: doc/BRIEF.md
# I2C Slave Transmitter with Status-Code Handshake

This block is the slave-transmit half of a two-wire serial controller. It watches the open-drain clock and data lines, detects START and STOP conditions, and collects the address byte. When the address matches its own address and asks for a read, it acknowledges. From then on it sends data bytes that software supplies. After every bus event it stops. It latches an 8-bit status code, raises an interrupt flag and holds the clock line low until software responds.

Software talks to the block through a data register and a small control word. The control word carries five bits: acknowledge-enable, general-call enable, stop, start request and the interrupt flag. Writing a data byte and clearing the flag sends the next byte. The acknowledge-enable value at that moment marks whether the byte is the last one. After the transfer ends, acknowledge-enable also decides whether the block answers its address again. A start request that is set when addressed mode ends is reported only as a pending flag. Master transfers, slave reception and clock generation belong to other blocks.

Control word bit positions (write and read): bit 0 acknowledge-enable, bit 1 general-call enable, bit 2 stop, bit 3 start request, bit 4 interrupt flag. Writing 0 to bit 4 clears the flag. Writing 1 to it has no effect.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset the status is F8h, the interrupt flag is 0, neither line is driven low and no start request is pending.
- R2: With acknowledge-enable set, a START followed by the own 7-bit address with the read bit (bit 0 = 1) is acknowledged by pulling SDA low in the ninth clock. The status becomes A8h, or B0h if an arbitration-lost pulse arrived since the last match, and the flag is set.
- R3: While the flag is set in any status other than 00h, SCL is held low. Clearing the flag releases it.
- R4: A loaded byte is shifted out MSB first, one bit per SCL low phase. When the master ACKs a byte that is not the last, the status becomes B8h.
- R5: When the master NACKs a byte, the status becomes C0h and SDA stays released.
- R6: A byte loaded while acknowledge-enable is 0 is the last byte. If the master ACKs it, the status becomes C8h.
- R7: Clearing the flag in C0h or C8h leaves addressed mode. The status becomes F8h, the flag is 0, and SDA is never driven, so a master that keeps clocking reads 1s.
- R8: Address recognition follows acknowledge-enable. General-call listening is active only when both acknowledge-enable and general-call enable are 1. With acknowledge-enable 0, the own address gets no ACK and sets no flag.
- R9: An address byte other than the own address, or the own address with the write bit (bit 0 = 0), gets no ACK and sets no flag.
- R10: A START or STOP during a data byte or its acknowledge bit gives status 00h with the flag set and both lines released. Writing stop = 1 returns the block to F8h with the flag cleared, sends nothing on the bus, and the stop bit reads back 0 again one cycle later.
- R11: A start request that is set when addressed mode ends raises start_pending. Writing the control word with the start-request bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | ADDR_W | Own slave address |
| arb_lost | input | 1 | Pulse: arbitration was lost as master during the address phase |
| data_we | input | 1 | Write strobe for the transmit data register |
| data_wdata | input | ADDR_W+1 | Transmit data byte |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 5 | Control word written by software |
| status | output | 8 | Status code |
| ctl_rdata | output | 5 | Control word read back, with the live flag in bit 4 |
| irq | output | 1 | Interrupt flag |
| start_pending | output | 1 | A start request is waiting for a free bus |
| addr_listen | output | 1 | Own-address recognition is active |
| gcall_listen | output | 1 | General-call recognition is active |

## Verification
The bench models an open-drain master that honours clock stretching and reads several transfer shapes. One is a multi-byte read ending with ACK on a last byte (A8, B8, C8). Another is an arbitration-lost entry that ends with NACK (B0, C0). A third is a last byte that is NACKed, which shows that NACK takes priority over the last-byte mark. Addresses that differ by one bit, and the own address with the write bit, separate a true match from a near miss. A START inserted in the middle of a byte of 1s separates a legal boundary from a bus error. Clocking on after the last byte shows whether the block keeps SDA released.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam logic [7:0] STS_SLA_R_ACK = 8'hA8;
  localparam logic [7:0] STS_ARB_SLA_R = 8'hB0;
  localparam logic [7:0] STS_DATA_ACK  = 8'hB8;
  localparam logic [7:0] STS_DATA_NACK = 8'hC0;
  localparam logic [7:0] STS_LAST_ACK  = 8'hC8;
  localparam logic [7:0] STS_IDLE      = 8'hF8;
  localparam logic [7:0] STS_BUS_ERR   = 8'h00;

  localparam int CTL_W  = 5;
  localparam int CB_ACK = 0;
  localparam int CB_GCE = 1;
  localparam int CB_STO = 2;
  localparam int CB_STA = 3;
  localparam int CB_FLG = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AACK,
    PH_HOLD,
    PH_TX,
    PH_ACK,
    PH_ERR
  } phase_e;
endpackage

// File: rtl/i2cst_line_mon.sv
module i2cst_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  localparam int LINES = 2;

  logic [LINES-1:0] pins;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_prev_q;

  assign pins = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], pins[g]};
      end
      assign lvl[g] = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev_q <= '1;
    else        lvl_prev_q <= lvl;
  end

  assign scl_rise  = lvl[0] & ~lvl_prev_q[0];
  assign scl_fall  = ~lvl[0] & lvl_prev_q[0];
  assign start_det = lvl[0] & lvl_prev_q[0] & lvl_prev_q[1] & ~lvl[1];
  assign stop_det  = lvl[0] & lvl_prev_q[0] & ~lvl_prev_q[1] & lvl[1];
  assign sda_lvl   = lvl[1];
endmodule

// File: rtl/i2cst_ctl_regs.sv
module i2cst_ctl_regs
  import i2cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             leave_evt,
  output logic             ack_en,
  output logic             gc_en,
  output logic             stop_req,
  output logic             sta_req,
  output logic             flag_clr,
  output logic             start_pending
);
  logic ack_q, gc_q, sto_q, sta_q, clr_q, pend_q;
  logic ack_d, gc_d, sto_d, sta_d, clr_d, pend_d;

  always_comb begin
    ack_d  = ack_q;
    gc_d   = gc_q;
    sta_d  = sta_q;
    sto_d  = 1'b0;
    clr_d  = 1'b0;
    pend_d = pend_q;
    if (ctl_we) begin
      ack_d = ctl_wdata[CB_ACK];
      gc_d  = ctl_wdata[CB_GCE];
      sta_d = ctl_wdata[CB_STA];
      sto_d = ctl_wdata[CB_STO];
      clr_d = ~ctl_wdata[CB_FLG];
      if (!ctl_wdata[CB_STA]) pend_d = 1'b0;
    end
    if (leave_evt && sta_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      gc_q   <= 1'b0;
      sto_q  <= 1'b0;
      sta_q  <= 1'b0;
      clr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ack_q  <= ack_d;
      gc_q   <= gc_d;
      sto_q  <= sto_d;
      sta_q  <= sta_d;
      clr_q  <= clr_d;
      pend_q <= pend_d;
    end
  end

  assign ack_en        = ack_q;
  assign gc_en         = gc_q;
  assign stop_req      = sto_q;
  assign sta_req       = sta_q;
  assign flag_clr      = clr_q;
  assign start_pending = pend_q;

  assert_stop_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_q && !ctl_we) |=> !sto_q)
    else $error("stop bit did not clear itself");

  assert_pending_from_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(sta_q))
    else $error("start pending raised without a request");
endmodule

// File: rtl/i2cst_engine.sv
module i2cst_engine
  import i2cst_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              arb_lost,
  input  logic              data_we,
  input  logic [ADDR_W:0]   data_wdata,
  input  logic              ack_en,
  input  logic              flag_clr,
  input  logic              stop_req,
  output logic [7:0]        status,
  output logic              si,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              leave_evt
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  phase_e             phase_q, phase_d;
  logic [7:0]         status_q, status_d;
  logic               si_q, si_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [FRAME_W-1:0] hold_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               last_q, last_d;
  logic               ack_q, ack_d;
  logic               sda_q, sda_d;
  logic               lost_q, lost_d;
  logic               leave_q, leave_d;
  logic               bus_cond;

  assign bus_cond = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (data_we) hold_q <= data_wdata;
  end

  always_comb begin
    phase_d  = phase_q;
    status_d = status_q;
    si_d     = si_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    last_d   = last_q;
    ack_d    = ack_q;
    sda_d    = sda_q;
    lost_d   = lost_q | arb_lost;
    leave_d  = 1'b0;
    if (stop_req) begin
      phase_d  = PH_IDLE;
      status_d = STS_IDLE;
      si_d     = 1'b0;
      sda_d    = 1'b0;
      lost_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_det && ack_en) begin
            phase_d = PH_ADDR;
            cnt_d   = '0;
          end
        end
        PH_ADDR: begin
          if (start_det) begin
            cnt_d = '0;
          end else if (stop_det) begin
            phase_d = PH_IDLE;
          end else if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[FRAME_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (sh_q[FRAME_W-1:1] == own_addr && sh_q[0]) begin
              phase_d = PH_AACK;
              sda_d   = 1'b1;
            end else begin
              phase_d = PH_IDLE;
            end
          end
        end
        PH_AACK: begin
          if (bus_cond) begin
            phase_d  = PH_ERR;
            status_d = STS_BUS_ERR;
            si_d     = 1'b1;
            sda_d    = 1'b0;
          end else if (scl_fall) begin
            phase_d  = PH_HOLD;
            sda_d    = 1'b0;
            si_d     = 1'b1;
            status_d = lost_q ? STS_ARB_SLA_R : STS_SLA_R_ACK;
            lost_d   = arb_lost;
          end
        end
        PH_HOLD: begin
          if (flag_clr) begin
            si_d = 1'b0;
            if (status_q == STS_DATA_NACK || status_q == STS_LAST_ACK) begin
              phase_d  = PH_IDLE;
              status_d = STS_IDLE;
              leave_d  = 1'b1;
            end else begin
              phase_d = PH_TX;
              sh_d    = hold_q;
              last_d  = ~ack_en;
              cnt_d   = '0;
              sda_d   = ~hold_q[FRAME_W-1];
            end
          end
        end
        PH_TX: begin
          if (bus_cond) begin
            phase_d  = PH_ERR;
            status_d = STS_BUS_ERR;
            si_d     = 1'b1;
            sda_d    = 1'b0;
          end else if (scl_fall) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              sda_d   = 1'b0;
              phase_d = PH_ACK;
            end else begin
              sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
              sda_d = ~sh_q[FRAME_W-2];
            end
          end
        end
        PH_ACK: begin
          if (bus_cond) begin
            phase_d  = PH_ERR;
            status_d = STS_BUS_ERR;
            si_d     = 1'b1;
          end else if (scl_rise) begin
            ack_d = ~sda_lvl;
          end else if (scl_fall) begin
            phase_d = PH_HOLD;
            si_d    = 1'b1;
            if (!ack_q)      status_d = STS_DATA_NACK;
            else if (last_q) status_d = STS_LAST_ACK;
            else             status_d = STS_DATA_ACK;
          end
        end
        PH_ERR: begin
          sda_d = 1'b0;
        end
        default: begin
          phase_d = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      status_q <= STS_IDLE;
      si_q     <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      last_q   <= 1'b0;
      ack_q    <= 1'b0;
      sda_q    <= 1'b0;
      lost_q   <= 1'b0;
      leave_q  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      status_q <= status_d;
      si_q     <= si_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      last_q   <= last_d;
      ack_q    <= ack_d;
      sda_q    <= sda_d;
      lost_q   <= lost_d;
      leave_q  <= leave_d;
    end
  end

  assign status    = status_q;
  assign si        = si_q;
  assign scl_oe    = (phase_q == PH_HOLD);
  assign sda_oe    = sda_q;
  assign leave_evt = leave_q;

  assert_idle_flag_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == STS_IDLE) |-> !si_q)
    else $error("flag set with idle status");

  assert_err_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == STS_BUS_ERR) |-> (!scl_oe && !sda_oe))
    else $error("bus held during bus error");

  assert_stretch_while_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (si_q && status_q != STS_BUS_ERR) |-> scl_oe)
    else $error("clock not stretched while flag set");

  assert_last_marks_c8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == STS_LAST_ACK) |-> last_q)
    else $error("C8 reported for a byte not marked last");
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2cst_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              arb_lost,
  input  logic              data_we,
  input  logic [ADDR_W:0]   data_wdata,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_wdata,
  output logic [7:0]        status,
  output logic [4:0]        ctl_rdata,
  output logic              irq,
  output logic              start_pending,
  output logic              addr_listen,
  output logic              gcall_listen
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic rst_n_s;
  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic ack_en, gc_en, stop_req, sta_req, flag_clr, leave_evt, si;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[RST_STAGES-1];

  i2cst_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl)
  );

  i2cst_ctl_regs u_ctl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .ctl_we        (ctl_we),
    .ctl_wdata     (ctl_wdata),
    .leave_evt     (leave_evt),
    .ack_en        (ack_en),
    .gc_en         (gc_en),
    .stop_req      (stop_req),
    .sta_req       (sta_req),
    .flag_clr      (flag_clr),
    .start_pending (start_pending)
  );

  i2cst_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_lvl    (sda_lvl),
    .own_addr   (own_addr),
    .arb_lost   (arb_lost),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .ack_en     (ack_en),
    .flag_clr   (flag_clr),
    .stop_req   (stop_req),
    .status     (status),
    .si         (si),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .leave_evt  (leave_evt)
  );

  assign irq          = si;
  assign ctl_rdata    = {si, sta_req, stop_req, gc_en, ack_en};
  assign addr_listen  = ack_en;
  assign gcall_listen = ack_en & gc_en;
endmodule

// File: tb/i2c_slave_tx_tb.sv
module i2c_slave_tx_tb;
  localparam int HALF = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic arb_lost = 1'b0, data_we = 1'b0, ctl_we = 1'b0;
  logic [7:0] data_wdata = '0;
  logic [4:0] ctl_wdata = '0;
  logic [7:0] status;
  logic [4:0] ctl_rdata;
  logic irq, start_pending, addr_listen, gcall_listen;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_sts[$];
  string      exp_tag[$];

  always #2 clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_slave_tx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .arb_lost(arb_lost),
    .data_we(data_we), .data_wdata(data_wdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .status(status), .ctl_rdata(ctl_rdata), .irq(irq),
    .start_pending(start_pending), .addr_listen(addr_listen),
    .gcall_listen(gcall_listen)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard driver side: expected status for the next flag
  task automatic expect_status(input logic [7:0] s, input string tag);
    exp_sts.push_back(s);
    exp_tag.push_back(tag);
  endtask

  // scoreboard monitor side
  initial begin
    forever begin
      @(posedge irq);
      @(negedge clk);
      if (exp_sts.size() == 0) begin
        chk(1'b0, "R9", "unexpected flag, status", status, 8'hF8);
      end else begin
        logic [7:0] s;
        string t;
        s = exp_sts.pop_front();
        t = exp_tag.pop_front();
        chk(status == s, t, "status on flag", status, s);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_ctl(input bit ack, input bit gce, input bit sto,
                        input bit sta, input bit flg);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = {flg, sta, sto, gce, ack};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic sw_data(input logic [7:0] b);
    @(negedge clk);
    data_we = 1'b1;
    data_wdata = b;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic wait_flag(input string tag);
    int n;
    n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(irq, tag, "flag raised", irq, 1);
    idle(2);
  endtask

  task automatic clk_bit(output logic v);
    @(negedge clk);
    m_scl = 1'b1;
    wait (scl_line == 1'b1);
    idle(HALF);
    v = sda_line;
    @(negedge clk);
    m_scl = 1'b0;
    idle(HALF);
  endtask

  task automatic m_start();
    @(negedge clk);
    m_sda = 1'b1;
    idle(2);
    m_scl = 1'b1;
    wait (scl_line == 1'b1);
    idle(HALF);
    m_sda = 1'b0;
    idle(HALF);
    m_scl = 1'b0;
    idle(HALF);
  endtask

  task automatic m_stop();
    @(negedge clk);
    m_sda = 1'b0;
    idle(HALF);
    m_scl = 1'b1;
    wait (scl_line == 1'b1);
    idle(HALF);
    m_sda = 1'b1;
    idle(HALF);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ackbit);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      clk_bit(d);
    end
    m_sda = 1'b1;
    clk_bit(ackbit);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    logic d;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(d);
      v[i] = d;
    end
    m_sda = mack ? 1'b0 : 1'b1;
    clk_bit(d);
    m_sda = 1'b1;
  endtask

  task automatic run_tests();
    logic a;
    logic [7:0] v;

    // R1 reset state
    chk(status == 8'hF8, "R1", "reset status", status, 8'hF8);
    chk(irq == 1'b0, "R1", "reset flag", irq, 0);
    chk(!scl_oe && !sda_oe, "R1", "reset line drive", {scl_oe, sda_oe}, 0);
    chk(start_pending == 1'b0, "R1", "reset pending", start_pending, 0);

    sw_ctl(1, 1, 0, 0, 1);
    idle(2);
    chk(addr_listen, "R8", "addr listen on", addr_listen, 1);
    chk(gcall_listen, "R8", "gcall listen on", gcall_listen, 1);

    // transfer 1: A8, B8, C8
    expect_status(8'hA8, "R2");
    m_start();
    write_byte({OWN, 1'b1}, a);
    chk(a == 1'b0, "R2", "address ack", a, 0);
    wait_flag("R2");
    chk(scl_oe && !scl_line, "R3", "clock stretched", scl_line, 0);
    sw_data(8'hA5);
    sw_ctl(1, 1, 0, 0, 0);
    idle(3);
    chk(!scl_oe, "R3", "clock released after clear", scl_oe, 0);
    expect_status(8'hB8, "R4");
    read_byte(1, v);
    chk(v == 8'hA5, "R4", "msb-first byte", v, 8'hA5);
    wait_flag("R4");
    sw_data(8'h3C);
    sw_ctl(0, 1, 0, 0, 0);
    expect_status(8'hC8, "R6");
    read_byte(1, v);
    chk(v == 8'h3C, "R6", "last byte", v, 8'h3C);
    wait_flag("R6");
    sw_ctl(1, 1, 0, 1, 0);
    idle(3);
    chk(status == 8'hF8, "R7", "status after leave", status, 8'hF8);
    chk(irq == 1'b0, "R7", "flag after leave", irq, 0);
    chk(start_pending, "R11", "pending raised", start_pending, 1);
    read_byte(0, v);
    chk(v == 8'hFF, "R7", "released sda after last", v, 8'hFF);
    m_stop();
    sw_ctl(1, 0, 0, 0, 1);
    idle(3);
    chk(!start_pending, "R11", "pending cleared", start_pending, 0);
    chk(!gcall_listen && addr_listen, "R8", "gcall needs enable",
        {addr_listen, gcall_listen}, 2'b10);

    // transfer 2: B0 then NACK -> C0
    @(negedge clk); arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    expect_status(8'hB0, "R2");
    m_start();
    write_byte({OWN, 1'b1}, a);
    wait_flag("R2");
    sw_data(8'h81);
    sw_ctl(1, 1, 0, 0, 0);
    expect_status(8'hC0, "R5");
    read_byte(0, v);
    chk(v == 8'h81, "R5", "byte before nack", v, 8'h81);
    wait_flag("R5");
    chk(!sda_oe, "R5", "sda released after nack", sda_oe, 0);
    sw_ctl(0, 1, 0, 0, 0);
    idle(3);
    chk(status == 8'hF8, "R7", "status after nack leave", status, 8'hF8);
    chk(!addr_listen && !gcall_listen, "R8", "recognition off",
        {addr_listen, gcall_listen}, 0);
    m_stop();
    m_start();
    write_byte({OWN, 1'b1}, a);
    chk(a == 1'b1, "R8", "no ack with recognition off", a, 1);
    m_stop();
    chk(!irq, "R8", "no flag with recognition off", irq, 0);

    // R9 near-miss addresses
    sw_ctl(1, 0, 0, 0, 1);
    m_start();
    write_byte({OWN ^ 7'h01, 1'b1}, a);
    chk(a == 1'b1, "R9", "foreign address nack", a, 1);
    m_stop();
    m_start();
    write_byte({OWN, 1'b0}, a);
    chk(a == 1'b1, "R9", "own write address nack", a, 1);
    m_stop();
    chk(!irq && status == 8'hF8, "R9", "no flag on miss", status, 8'hF8);

    // R10 bus error: START inside a data byte of ones
    expect_status(8'hA8, "R2");
    m_start();
    write_byte({OWN, 1'b1}, a);
    wait_flag("R2");
    sw_data(8'hFF);
    sw_ctl(1, 0, 0, 0, 0);
    expect_status(8'h00, "R10");
    for (int i = 0; i < 3; i++) clk_bit(a);
    @(negedge clk);
    m_scl = 1'b1;
    wait (scl_line == 1'b1);
    idle(HALF);
    m_sda = 1'b0;
    idle(HALF);
    wait_flag("R10");
    chk(!scl_oe && !sda_oe, "R10", "lines released in error", {scl_oe, sda_oe}, 0);
    sw_ctl(1, 0, 1, 0, 1);
    idle(2);
    chk(status == 8'hF8 && !irq, "R10", "recovered status", status, 8'hF8);
    chk(ctl_rdata[2] == 1'b0, "R10", "stop bit self-cleared", ctl_rdata[2], 0);
    chk(!scl_oe && !sda_oe, "R10", "no bus activity on recovery", {scl_oe, sda_oe}, 0);
    idle(2);
    m_sda = 1'b1;
    idle(HALF);

    // last byte NACKed: NACK wins over the last mark
    expect_status(8'hA8, "R2");
    m_start();
    write_byte({OWN, 1'b1}, a);
    wait_flag("R2");
    sw_data(8'h00);
    sw_ctl(0, 0, 0, 0, 0);
    expect_status(8'hC0, "R5");
    read_byte(0, v);
    chk(v == 8'h00, "R4", "zero byte", v, 0);
    wait_flag("R5");
    sw_ctl(1, 0, 0, 0, 0);
    idle(3);
    chk(status == 8'hF8 && !irq, "R7", "final idle", status, 8'hF8);
    m_stop();
    idle(20);
    chk(exp_sts.size() == 0, "R2", "all expected flags seen", exp_sts.size(), 0);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(4);
    fork
      begin : main_flow
        run_tests();
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule